// File: doc/BRIEF.md
# Multi-Lane SPI Command Sequencer

This block runs one enhanced serial-flash style transaction at a time. A transaction has up to four phases in fixed order: an instruction, an address, a dummy gap and a data phase. Each phase drives or samples one, two or four data lines. Each active cycle stands for one serial clock period. The surrounding controller turns `sclk_en_o` into the actual serial clock and supplies the configuration, the transmit word stream and the receive word sink.

A start pulse captures the configuration and checks it. The block then pulls the instruction word and the address word(s) from the transmit stream. Serial activity begins only after all of them are in hand. In multi-line phases the most significant bits go out first. The higher-order bit of each group sits on the higher-numbered line. In a read, the incoming bit groups are packed into right-justified words. In a write, the low bits of each transmit word are shifted out.

Top module: `qspi_seq`

## Requirements
- R1: After reset `busy_o`, `sel_o`, `sclk_en_o`, `tx_ready_o`, `rx_valid_o` and `err_o` are 0, and `sd_oe_o` is 0.
- R2: Phases run in the order instruction, address, dummy, data, and each phase with zero length is skipped. `inst_len_i` codes 0/1/2/3 mean 0/4/8/16 instruction bits. The address is 4 × `addr_len_i` bits (0 to 60).
- R3: `line_mode_i` 0 drives one lane on line 0, 1 drives lanes on lines 1:0, and 2 drives lanes on lines 3:0. Bits go out MSB first, with the earlier bit of a group on the higher line. `sd_oe_o` is 4'b0001, 4'b0011 or 4'b1111 exactly for the lanes in use, and 0 otherwise.
- R4: `xfer_fmt_i` 0 sends both instruction and address on one lane. 1 sends the instruction on one lane and the address on the selected lanes. 2 sends both on the selected lanes.
- R5: In a read with `line_mode_i` 1 or 2, a dummy phase of `wait_cyc_i` cycles follows the command. During it `sclk_en_o` is 1, every `sd_oe_o` bit is 0, and line values are not captured. In writes and in single-lane mode, no dummy cycles are inserted.
- R6: A read (`xfer_mode_i`=2) samples `sd_i[1]` in single-lane mode, or the active lanes otherwise. Each frame is `frame_code_i`+1 bits, and there are `num_frames_i`+1 frames. Each frame appears right-justified and zero-padded on `rx_data_o`, with `rx_valid_o` high for the one cycle after its last sample cycle. All `sd_oe_o` bits are 0 in this phase.
- R7: A write (`xfer_mode_i`=1) takes `num_frames_i`+1 words from the stream and sends the low `frame_code_i`+1 bits of each. The upper bits are ignored.
- R8: Before any serial cycle, the stream must supply the instruction word (low 16 bits, when present). It must then supply the address: the upper part first, then the low 32 bits, when longer than 32 bits. `sclk_en_o` stays 0 until all of these words are accepted.
- R9: A start with an illegal configuration sets `err_o` and starts nothing. Illegal means: line mode 3, format 3, a transfer mode other than 1 or 2, `frame_code_i` below 3, an even `frame_code_i` in dual mode, or `frame_code_i[1:0]`≠3 in quad mode. `err_o` holds until a start with a legal configuration is accepted.
- R10: `start_i` while `busy_o` is 1 is ignored.
- R11: `sel_o` is 1 throughout the serial phases, and `sclk_en_o` is never 1 while `sel_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one serial period per active cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transaction when idle |
| line_mode_i | input | 2 | 0 single, 1 dual, 2 quad lanes |
| xfer_fmt_i | input | 2 | Lane use of instruction and address phases |
| xfer_mode_i | input | 2 | 1 write, 2 read |
| inst_len_i | input | 2 | Instruction length code |
| addr_len_i | input | 4 | Address length in 4-bit units |
| wait_cyc_i | input | 5 | Dummy cycles before read data |
| frame_code_i | input | 5 | Data frame size minus one |
| num_frames_i | input | FRAME_CNT_W | Frame count minus one |
| tx_data_i | input | 32 | Transmit word stream data |
| tx_valid_i | input | 1 | Transmit word available |
| tx_ready_o | output | 1 | Block accepts a transmit word |
| sd_i | input | 4 | Data lines in |
| sd_o | output | 4 | Data lines out |
| sd_oe_o | output | 4 | Per-line output enable |
| sclk_en_o | output | 1 | This cycle is a serial clock period |
| sel_o | output | 1 | Target select, active high |
| busy_o | output | 1 | Transaction in progress |
| err_o | output | 1 | Sticky illegal-configuration flag |
| rx_data_o | output | 32 | Received frame, right-justified |
| rx_valid_o | output | 1 | Received frame strobe |

## Verification
The hardest state to reach is a started transaction that has accepted only part of its command words. No serial cycle may occur there. The stimulus reaches it by holding the transmit stream back for a dozen cycles after a start whose address spans two words, then releasing it. A second hard case is a start pulse that arrives in the middle of a run, carrying an illegal configuration. It must neither raise the error flag nor disturb the bit stream. The stimulus fires it while a dual-lane read with a dummy gap is still running, and the scoreboard keeps checking every lane value and received word.

// File: rtl/qspi_seq_pkg.sv
package qspi_seq_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = $clog2(2 * WORD_W) + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_LD_INST, S_LD_AHI, S_LD_ALO, S_INST, S_ADDR, S_WAIT, S_DATA
  } phase_e;

  typedef struct packed {
    logic [2:0] inst_w;
    logic [2:0] addr_w;
    logic [2:0] data_w;
    logic [4:0] inst_bits;
    logic [6:0] addr_bits;
    logic [5:0] frame_bits;
    logic [4:0] wait_n;
    logic       rd;
  } cfg_t;

  function automatic logic [2:0] lanes_of(input logic [1:0] m);
    case (m)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic phase_e first_serial(input cfg_t c);
    if (c.inst_bits != 0) return S_INST;
    if (c.addr_bits != 0) return S_ADDR;
    if (c.wait_n != 0)    return S_WAIT;
    return S_DATA;
  endfunction

  function automatic phase_e phase_after(input cfg_t c, input phase_e p);
    case (p)
      S_IDLE:
        if (c.inst_bits != 0)      return S_LD_INST;
        else if (c.addr_bits > 32) return S_LD_AHI;
        else if (c.addr_bits != 0) return S_LD_ALO;
        else                       return first_serial(c);
      S_LD_INST:
        if (c.addr_bits > 32)      return S_LD_AHI;
        else if (c.addr_bits != 0) return S_LD_ALO;
        else                       return first_serial(c);
      S_LD_AHI: return S_LD_ALO;
      S_LD_ALO: return first_serial(c);
      S_INST:
        if (c.addr_bits != 0)      return S_ADDR;
        else if (c.wait_n != 0)    return S_WAIT;
        else                       return S_DATA;
      S_ADDR:   return (c.wait_n != 0) ? S_WAIT : S_DATA;
      S_WAIT:   return S_DATA;
      default:  return S_IDLE;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] entry_cnt(input cfg_t c, input phase_e p);
    case (p)
      S_INST:  return CNT_W'(c.inst_bits);
      S_ADDR:  return CNT_W'(c.addr_bits);
      S_WAIT:  return CNT_W'(c.wait_n);
      S_DATA:  return c.rd ? CNT_W'(c.frame_bits) : '0;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/qspi_cfg_check.sv
module qspi_cfg_check
  import qspi_seq_pkg::*;
(
  input  logic [1:0] line_mode_i,
  input  logic [1:0] xfer_fmt_i,
  input  logic [1:0] xfer_mode_i,
  input  logic [1:0] inst_len_i,
  input  logic [3:0] addr_len_i,
  input  logic [4:0] wait_cyc_i,
  input  logic [4:0] frame_code_i,
  output logic       legal_o,
  output cfg_t       cfg_o
);
  logic       multi;
  logic [2:0] w;
  logic       size_ok;

  assign multi = (line_mode_i != 2'd0);
  assign w     = lanes_of(line_mode_i);

  always_comb begin
    case (line_mode_i)
      2'd1:    size_ok = frame_code_i[0];
      2'd2:    size_ok = (frame_code_i[1:0] == 2'b11);
      default: size_ok = 1'b1;
    endcase
  end

  assign legal_o = (line_mode_i != 2'd3) && (xfer_fmt_i != 2'd3) &&
                   (xfer_mode_i == 2'd1 || xfer_mode_i == 2'd2) &&
                   (frame_code_i >= 5'd3) && size_ok;

  always_comb begin
    cfg_o.inst_w = (xfer_fmt_i == 2'd2) ? w : 3'd1;
    cfg_o.addr_w = (xfer_fmt_i != 2'd0) ? w : 3'd1;
    cfg_o.data_w = w;
    case (inst_len_i)
      2'd0:    cfg_o.inst_bits = 5'd0;
      2'd1:    cfg_o.inst_bits = 5'd4;
      2'd2:    cfg_o.inst_bits = 5'd8;
      default: cfg_o.inst_bits = 5'd16;
    endcase
    cfg_o.addr_bits  = {1'b0, addr_len_i, 2'b00};
    cfg_o.frame_bits = {1'b0, frame_code_i} + 6'd1;
    cfg_o.rd         = (xfer_mode_i == 2'd2);
    cfg_o.wait_n     = (multi && cfg_o.rd) ? wait_cyc_i : 5'd0;
  end
endmodule

// File: rtl/qspi_lane_mux.sv
module qspi_lane_mux (
  input  logic [2:0] width_i,
  input  logic       drive_i,
  input  logic [3:0] top_i,
  input  logic [3:0] sd_i,
  output logic [3:0] sd_o,
  output logic [3:0] oe_o,
  output logic [3:0] smp_o
);
  always_comb begin
    case (width_i)
      3'd1: begin
        sd_o  = {3'b000, top_i[3]};
        oe_o  = 4'b0001;
        smp_o = {3'b000, sd_i[1]};
      end
      3'd2: begin
        sd_o  = {2'b00, top_i[3:2]};
        oe_o  = 4'b0011;
        smp_o = {2'b00, sd_i[1:0]};
      end
      default: begin
        sd_o  = top_i;
        oe_o  = 4'b1111;
        smp_o = sd_i;
      end
    endcase
    if (!drive_i) begin
      sd_o = 4'b0000;
      oe_o = 4'b0000;
    end
  end
endmodule

// File: rtl/qspi_rx_gather.sv
module qspi_rx_gather
  import qspi_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              last_i,
  input  logic [2:0]        width_i,
  input  logic [3:0]        bits_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o
);
  logic [WORD_W-1:0] acc_q, acc_nxt;

  assign acc_nxt = (acc_q << width_i) | WORD_W'(bits_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clr_i) begin
        acc_q <= '0;
      end else if (en_i) begin
        if (last_i) begin
          data_o  <= acc_nxt;
          valid_o <= 1'b1;
          acc_q   <= '0;
        end else begin
          acc_q <= acc_nxt;
        end
      end
    end
  end

  // R6
  frame_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && last_i && !clr_i) |=> valid_o);
  // R6
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && last_i) |=> !valid_o);
endmodule

// File: rtl/qspi_seq.sv
module qspi_seq
  import qspi_seq_pkg::*;
#(
  parameter int FRAME_CNT_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [1:0]             line_mode_i,
  input  logic [1:0]             xfer_fmt_i,
  input  logic [1:0]             xfer_mode_i,
  input  logic [1:0]             inst_len_i,
  input  logic [3:0]             addr_len_i,
  input  logic [4:0]             wait_cyc_i,
  input  logic [4:0]             frame_code_i,
  input  logic [FRAME_CNT_W-1:0] num_frames_i,
  input  logic [31:0]            tx_data_i,
  input  logic                   tx_valid_i,
  output logic                   tx_ready_o,
  input  logic [3:0]             sd_i,
  output logic [3:0]             sd_o,
  output logic [3:0]             sd_oe_o,
  output logic                   sclk_en_o,
  output logic                   sel_o,
  output logic                   busy_o,
  output logic                   err_o,
  output logic [31:0]            rx_data_o,
  output logic                   rx_valid_o
);
  localparam int ADDR_W = 2 * WORD_W;

  cfg_t                   cfg_d, cfg_q, cfg_use;
  logic                   legal;
  phase_e                 state_q, nxt;
  logic [15:0]            inst_q;
  logic [ADDR_W-1:0]      addr_q;
  logic [WORD_W-1:0]      sh_q;
  logic [CNT_W-1:0]       cnt_q, cnt_entry;
  logic [FRAME_CNT_W-1:0] frames_q;
  logic                   have_q, err_q, go, hs;
  logic [2:0]             w_cur;
  logic                   frame_end, drive, rd_smp;
  logic [3:0]             top, smp;

  qspi_cfg_check i_cfg (
    .line_mode_i (line_mode_i),
    .xfer_fmt_i  (xfer_fmt_i),
    .xfer_mode_i (xfer_mode_i),
    .inst_len_i  (inst_len_i),
    .addr_len_i  (addr_len_i),
    .wait_cyc_i  (wait_cyc_i),
    .frame_code_i(frame_code_i),
    .legal_o     (legal),
    .cfg_o       (cfg_d)
  );

  always_comb begin
    case (state_q)
      S_INST:  begin w_cur = cfg_q.inst_w; top = inst_q[15:12]; end
      S_ADDR:  begin w_cur = cfg_q.addr_w; top = addr_q[ADDR_W-1 -: 4]; end
      default: begin w_cur = cfg_q.data_w; top = sh_q[WORD_W-1 -: 4]; end
    endcase
  end

  assign frame_end  = (cnt_q == CNT_W'(w_cur));
  assign tx_ready_o = (state_q == S_LD_INST) || (state_q == S_LD_AHI) ||
                      (state_q == S_LD_ALO) ||
                      (state_q == S_DATA && !cfg_q.rd && !have_q);
  assign hs         = tx_valid_i && tx_ready_o;
  assign drive      = (state_q == S_INST) || (state_q == S_ADDR) ||
                      (state_q == S_DATA && !cfg_q.rd && have_q);
  assign rd_smp     = (state_q == S_DATA) && cfg_q.rd;
  assign sclk_en_o  = (state_q == S_INST) || (state_q == S_ADDR) ||
                      (state_q == S_WAIT) ||
                      (state_q == S_DATA && (cfg_q.rd || have_q));
  assign sel_o      = (state_q == S_INST) || (state_q == S_ADDR) ||
                      (state_q == S_WAIT) || (state_q == S_DATA);
  assign busy_o     = (state_q != S_IDLE);
  assign err_o      = err_q;

  always_comb begin
    go      = 1'b0;
    cfg_use = (state_q == S_IDLE) ? cfg_d : cfg_q;
    nxt     = phase_after(cfg_use, state_q);
    case (state_q)
      S_IDLE:                          go = start_i && legal;
      S_LD_INST, S_LD_AHI, S_LD_ALO:   go = hs;
      S_INST, S_ADDR:                  go = frame_end;
      S_WAIT:                          go = (cnt_q == CNT_W'(1));
      S_DATA: go = frame_end && (frames_q == '0) && (cfg_q.rd || have_q);
      default:                         go = 1'b0;
    endcase
    cnt_entry = entry_cnt(cfg_use, nxt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      cfg_q    <= '0;
      inst_q   <= '0;
      addr_q   <= '0;
      sh_q     <= '0;
      cnt_q    <= '0;
      frames_q <= '0;
      have_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (state_q == S_IDLE && start_i) begin
        err_q <= !legal;
        if (legal) begin
          cfg_q    <= cfg_d;
          addr_q   <= '0;
          frames_q <= num_frames_i;
        end
      end
      if (go) begin
        state_q <= nxt;
        cnt_q   <= cnt_entry;
        have_q  <= 1'b0;
      end
      case (state_q)
        S_LD_INST: if (hs) inst_q <= tx_data_i[15:0] << (5'd16 - cfg_q.inst_bits);
        S_LD_AHI:  if (hs) addr_q <= {tx_data_i, 32'h0};
        S_LD_ALO:  if (hs) addr_q <= {addr_q[ADDR_W-1:WORD_W], tx_data_i}
                                     << (7'd64 - cfg_q.addr_bits);
        S_INST: begin
          inst_q <= inst_q << w_cur;
          if (!go) cnt_q <= cnt_q - CNT_W'(w_cur);
        end
        S_ADDR: begin
          addr_q <= addr_q << w_cur;
          if (!go) cnt_q <= cnt_q - CNT_W'(w_cur);
        end
        S_WAIT: if (!go) cnt_q <= cnt_q - CNT_W'(1);
        S_DATA: begin
          if (cfg_q.rd) begin
            if (!go) begin
              if (frame_end) begin
                frames_q <= frames_q - 1'b1;
                cnt_q    <= CNT_W'(cfg_q.frame_bits);
              end else begin
                cnt_q <= cnt_q - CNT_W'(w_cur);
              end
            end
          end else if (!have_q) begin
            if (hs) begin
              sh_q   <= tx_data_i << (6'd32 - cfg_q.frame_bits);
              cnt_q  <= CNT_W'(cfg_q.frame_bits);
              have_q <= 1'b1;
            end
          end else begin
            sh_q <= sh_q << w_cur;
            if (!go) begin
              if (frame_end) begin
                have_q   <= 1'b0;
                frames_q <= frames_q - 1'b1;
              end else begin
                cnt_q <= cnt_q - CNT_W'(w_cur);
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  qspi_lane_mux i_mux (
    .width_i(w_cur),
    .drive_i(drive),
    .top_i  (top),
    .sd_i   (sd_i),
    .sd_o   (sd_o),
    .oe_o   (sd_oe_o),
    .smp_o  (smp)
  );

  qspi_rx_gather i_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == S_IDLE),
    .en_i   (rd_smp),
    .last_i (frame_end),
    .width_i(w_cur),
    .bits_i (smp),
    .data_o (rx_data_o),
    .valid_o(rx_valid_o)
  );

  // R11
  sclk_needs_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_en_o |-> sel_o);
  // R3
  oe_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_oe_o == 4'h0) || (sd_oe_o == 4'h1) || (sd_oe_o == 4'h3) || (sd_oe_o == 4'hF));
  // R5
  wait_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT) |-> (sd_oe_o == 4'h0 && sclk_en_o));
  // R9
  bad_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !legal) |=> (err_o && !busy_o));
  // R10
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(err_o));
  // R8
  load_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o && !sel_o |-> !sclk_en_o);
endmodule

// File: tb/test_qspi_seq.sv
module test_qspi_seq;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0] oe;
    logic [3:0] sd;
    logic [3:0] req;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  line_mode_i = '0, xfer_fmt_i = '0, xfer_mode_i = 2'd1, inst_len_i = '0;
  logic [3:0]  addr_len_i = '0;
  logic [4:0]  wait_cyc_i = '0, frame_code_i = 5'd7;
  logic [15:0] num_frames_i = '0;
  logic [31:0] tx_data_i = '0;
  logic        tx_valid_i = 1'b0;
  logic        tx_ready_o;
  logic [3:0]  sd_i = '0, sd_o, sd_oe_o;
  logic        sclk_en_o, sel_o, busy_o, err_o, rx_valid_o;
  logic [31:0] rx_data_o;

  int total = 0, bad = 0, ser_cnt = 0;
  bit hold_tx = 0, hs_pend = 0, finished = 0;
  item_t exp_q[$];
  logic [3:0] in_q[$];
  logic [31:0] rx_q[$], tx_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  qspi_seq i_qspi_seq (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: tx stream driver, lane scoreboard, rx scoreboard
  always @(negedge clk_i) begin
    if (hs_pend && tx_q.size() > 0) void'(tx_q.pop_front());
    tx_valid_i = !hold_tx && tx_q.size() > 0;
    tx_data_i  = (tx_q.size() > 0) ? tx_q[0] : 32'h0;
    hs_pend    = tx_valid_i && tx_ready_o;
    if (sclk_en_o) begin
      item_t it;
      ser_cnt++;
      chk(sel_o, "R11 sel", {63'b0, sel_o}, 64'd1);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 extra serial cycle", {56'b0, sd_oe_o, sd_o}, 64'h0);
      end else begin
        it = exp_q.pop_front();
        chk({sd_oe_o, sd_o} == {it.oe, it.sd}, $sformatf("R%0d lanes", it.req),
            {56'b0, sd_oe_o, sd_o}, {56'b0, it.oe, it.sd});
      end
      if (sd_oe_o == 4'h0) sd_i = (in_q.size() > 0) ? in_q.pop_front() : 4'h0;
    end
    if (rx_valid_o) begin
      if (rx_q.size() == 0) chk(1'b0, "R6 extra word", {32'b0, rx_data_o}, 64'h0);
      else begin
        logic [31:0] e;
        e = rx_q.pop_front();
        chk(rx_data_o == e, "R6 rx word", {32'b0, rx_data_o}, {32'b0, e});
      end
    end
  end

  task automatic emit(input logic [63:0] v, input int nb, input int ln, input logic [3:0] req);
    for (int i = nb - ln; i >= 0; i -= ln) begin
      item_t it;
      it.oe  = 4'((1 << ln) - 1);
      it.sd  = 4'((v >> i) & ((64'd1 << ln) - 1));
      it.req = req;
      exp_q.push_back(it);
    end
  endtask

  task automatic plan(input int lm, fmt, mode, il, al, wc, fc, nf, input logic [63:0] addr);
    int w, iw, aw, ib, ab, fb;
    logic [31:0] inst;
    w  = (lm == 0) ? 1 : (lm == 1) ? 2 : 4;
    iw = (fmt == 2) ? w : 1;
    aw = (fmt != 0) ? w : 1;
    ib = (il == 0) ? 0 : (il == 1) ? 4 : (il == 2) ? 8 : 16;
    ab = al * 4;
    fb = fc + 1;
    inst = $urandom;
    if (ib != 0) begin tx_q.push_back(inst); emit({32'b0, inst} & ((64'd1 << ib) - 1), ib, iw, 4'd4); end
    if (ab > 32) tx_q.push_back(addr[63:32]);
    if (ab != 0) begin tx_q.push_back(addr[31:0]); emit(addr & ((64'd1 << ab) - 1), ab, aw, 4'd2); end
    if (lm != 0 && mode == 2)
      for (int k = 0; k < wc; k++) begin
        item_t it;
        it = '{oe: 4'h0, sd: 4'h0, req: 4'd5};
        exp_q.push_back(it);
        in_q.push_back(4'hF);  // R5 dummy-phase input must not be captured
      end
    for (int f = 0; f <= nf; f++) begin
      logic [31:0] word, val;
      word = $urandom;
      val  = 32'({32'b0, word} & ((64'd1 << fb) - 1));
      if (mode == 2) begin
        rx_q.push_back(val);
        for (int i = fb - w; i >= 0; i -= w) begin
          item_t it;
          logic [3:0] c;
          it = '{oe: 4'h0, sd: 4'h0, req: 4'd6};
          exp_q.push_back(it);
          c = 4'((val >> i) & ((1 << w) - 1));
          in_q.push_back((w == 1) ? {2'b00, c[0], 1'b0} : c);
        end
      end else begin
        tx_q.push_back(word);  // R7 upper bits of word are garbage
        emit({32'b0, val}, fb, w, 4'd7);
      end
    end
  endtask

  task automatic set_cfg(input int lm, fmt, mode, il, al, wc, fc, nf);
    line_mode_i  = 2'(lm);
    xfer_fmt_i   = 2'(fmt);
    xfer_mode_i  = 2'(mode);
    inst_len_i   = 2'(il);
    addr_len_i   = 4'(al);
    wait_cyc_i   = 5'(wc);
    frame_code_i = 5'(fc);
    num_frames_i = 16'(nf);
  endtask

  task automatic run_txn(input int lm, fmt, mode, il, al, wc, fc, nf, input int hold, input bit poke);
    int guard, s0;
    plan(lm, fmt, mode, il, al, wc, fc, nf, {$urandom, $urandom});
    set_cfg(lm, fmt, mode, il, al, wc, fc, nf);
    hold_tx = (hold > 0);
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    if (hold > 0) begin
      s0 = ser_cnt;
      repeat (hold) @(negedge clk_i);
      // R8 no serial cycle before command words arrive
      chk(ser_cnt == s0 && busy_o, "R8 held stream", 64'(ser_cnt - s0), 64'd0);
      hold_tx = 0;
    end
    if (poke) begin
      repeat (6) @(negedge clk_i);
      line_mode_i = 2'd3;
      start_i = 1'b1;
      @(negedge clk_i); start_i = 1'b0;
      line_mode_i = 2'(lm);
      @(negedge clk_i);
      chk(!err_o && busy_o, "R10 start while busy", {62'b0, err_o, busy_o}, 64'd1);
    end
    guard = 0;
    while (busy_o && guard < 5000) begin @(negedge clk_i); guard++; end
    @(negedge clk_i);
    chk(exp_q.size() == 0, "R2 serial stream length", 64'(exp_q.size()), 64'd0);
    chk(rx_q.size() == 0 && tx_q.size() == 0, "R6 R7 word counts",
        64'(rx_q.size() + tx_q.size()), 64'd0);
    chk(!sel_o && !busy_o && !err_o, "R11 idle after run", {61'b0, sel_o, busy_o, err_o}, 64'd0);
  endtask

  task automatic try_bad(input int lm, fmt, mode, fc);
    int s0;
    s0 = ser_cnt;
    set_cfg(lm, fmt, mode, 2, 2, 0, fc, 0);
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    // R9 illegal configuration rejected
    chk(err_o && !busy_o && ser_cnt == s0 && !tx_ready_o, "R9 illegal cfg",
        {62'b0, err_o, busy_o}, 64'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset values
    chk({busy_o, sel_o, sclk_en_o, tx_ready_o, rx_valid_o, err_o, sd_oe_o} == '0, "R1 in reset",
        {54'b0, busy_o, sel_o, sclk_en_o, tx_ready_o, rx_valid_o, err_o, sd_oe_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({busy_o, sel_o, sclk_en_o, tx_ready_o, err_o, sd_oe_o} == '0, "R1 after reset",
        {55'b0, busy_o, sel_o, sclk_en_o, tx_ready_o, err_o, sd_oe_o}, 64'd0);
    // R2 R3 R4 R5 R6: quad, all multi-lane, dummy gap, 32-bit read
    run_txn(2, 2, 2, 2, 6, 4, 31, 1, 0, 0);
    // R4 R5 R7: quad write, command on one lane, wait ignored
    run_txn(2, 0, 1, 2, 6, 3, 7, 2, 0, 0);
    // R4 R6: dual, single-lane instruction, dual address, 6-bit right-justified
    run_txn(1, 1, 2, 3, 2, 0, 5, 0, 0, 0);
    // R2 R5 R6: single lane, 60-bit address, wait ignored, sample line 1
    run_txn(0, 0, 2, 2, 15, 7, 11, 1, 0, 0);
    // R2 R7: no instruction, no address, quad write
    run_txn(2, 2, 1, 0, 0, 9, 15, 1, 0, 0);
    // R8 R10: dual read, 36-bit address held back, start poked while busy
    run_txn(1, 2, 2, 1, 9, 2, 3, 2, 12, 1);
    // R9 illegal cases
    try_bad(3, 0, 1, 7);
    try_bad(0, 3, 1, 7);
    try_bad(0, 0, 0, 7);
    try_bad(2, 2, 3, 7);
    try_bad(2, 2, 2, 5);
    try_bad(1, 1, 2, 6);
    try_bad(0, 0, 1, 2);
    // R9 a legal start clears the flag
    run_txn(0, 0, 1, 1, 1, 0, 3, 0, 0, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule